// File: doc/BRIEF.md
# Carry-Chained 8-bit Stack ALU

This block is the arithmetic and logic unit of a small stack processor. It is purely combinational. A 5-bit operation code selects the function. Operand A is the byte at the top of the stack. Operand B is the deeper operand, and unary operations ignore it. A single carry flag comes in and an updated carry flag goes out. The surrounding datapath fetches the operands, writes back the result byte and stores the returned flag. Memory access, stack-pointer movement and flag storage all stay outside this block.

The one flag has a different meaning for each operation family. Arithmetic operations use it as carry-in or borrow-in and report overflow or underflow on it. Logic operations report a zero result on it. The conditional select reads it as its condition. Rotate always clears it. Increment, decrement and negate leave it untouched. One shared ripple carry chain serves all five adder-based operations. A staged barrel rotator handles rotate.

Top module: `stack_alu`

## Requirements
- R1: Code 0 (add) returns (B + A + carry_in) mod 256. carry_out is 1 exactly when the unsigned sum exceeds 0xFF.
- R2: Code 1 (subtract) returns (B - A - carry_in) mod 256. carry_out is 1 exactly when B < A + carry_in (borrow).
- R3: Code 2 (select) returns A when carry_in is 1 and B when carry_in is 0. carry_out equals carry_in.
- R4: Code 3 (rotate) returns B rotated left by the value of A's low 3 bits, so an amount of 8 acts as 0. carry_out is 0.
- R5: Codes 4, 5 and 6 return A OR B, A AND B and A XOR B. carry_out is 1 exactly when the result is 0x00.
- R6: Code 7 (XAND) always returns 0x00 and carry_out 1, whatever the operands are.
- R7: Code 13 (NOT) returns ~A. Code 14 (buffer) returns A. For both, carry_out is 1 exactly when the result is 0x00.
- R8: Code 11 (shift left) returns {A[6:0], 0} with carry_out = A[7].
- R9: Code 12 (shift right) returns {0, A[7:1]} with carry_out = A[0].
- R10: Code 8 returns A + 1, code 9 returns A - 1 and code 10 returns -A (two's complement), all mod 256. For these three, carry_out equals carry_in.
- R11: Codes 15 to 31 are unused. They return A unchanged with carry_out equal to carry_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 8 | Top-of-stack operand A |
| opnd_b | input | 8 | Second operand B (unused by unary operations) |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Result byte |
| carry_out | output | 1 | New carry flag |

## Verification
Arithmetic is tried at the 0xFF/0x00 wrap with and without carry-in. These vectors separate a correct carry or borrow from an inverted one or one that ignores carry-in. A full sweep of subtract with equal operands confirms the borrow never fires spuriously. Rotate is swept over every amount with a single set bit, so a wrong direction, a wrong stage or a missing wrap at 8 shows up. Logic operations are paired so that one vector gives a zero result and its partner a non-zero one. This exposes a zero flag that is stuck or inverted. The unused codes and the pass-through operations are tried with carry_in at both values to show the flag is left untouched.

// File: rtl/stack_alu_pkg.sv
// Package: shared operation codes and width constants for the stack ALU.
// Assumes an 8-bit datapath; codes not listed are treated as unused.
package stack_alu_pkg;

    localparam int unsigned OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_SEL  = 5'd2,
        OP_ROT  = 5'd3,
        OP_OR   = 5'd4,
        OP_AND  = 5'd5,
        OP_XOR  = 5'd6,
        OP_XAND = 5'd7,
        OP_INC  = 5'd8,
        OP_DEC  = 5'd9,
        OP_NEG  = 5'd10,
        OP_SHL  = 5'd11,
        OP_SHR  = 5'd12,
        OP_NOT  = 5'd13,
        OP_BUF  = 5'd14
    } alu_op_e;

endpackage

// File: rtl/alu_carry_chain.sv
// Ripple carry adder shared by add, subtract, increment, decrement, negate.
// Computes x + y + ci. Subtraction is expected to arrive pre-inverted from the caller.
module alu_carry_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co
);

    logic [WIDTH:0] carry;

    assign carry[0] = ci;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = x_in[i] ^ y_in[i] ^ carry[i];
        assign carry[i+1] = (x_in[i] & y_in[i]) | (carry[i] & (x_in[i] ^ y_in[i]));
    end

    assign co = carry[WIDTH];

endmodule

// File: rtl/alu_bitwise.sv
// Bitwise unit: OR, AND, XOR, XAND (constant zero), NOT and buffer.
// Assumes the caller checks the zero flag; other codes yield A.
module alu_bitwise
    import stack_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    // Select the bitwise function for the given code.
    always_comb begin
        case (op)
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            OP_XAND: y = '0;
            OP_NOT:  y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
// Shift/rotate unit: staged left rotate of B by A's low log2(WIDTH) bits,
// plus single-bit zero-fill shifts of A that return the bit shifted out.
module alu_shifter
    import stack_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             c
);

    localparam int unsigned SHW = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [SHW+1];
    logic [SHW-1:0]   amt;

    assign amt      = a[SHW-1:0];
    assign stage[0] = b;

    // Barrel rotator: stage k rotates by 2**k when amount bit k is set.
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        assign stage[k+1] = amt[k]
            ? {stage[k][WIDTH-1-D:0], stage[k][WIDTH-1:WIDTH-D]}
            : stage[k];
    end

    // Pick the rotate or shift result and the bit that leaves.
    always_comb begin
        case (op)
            OP_SHL: begin
                y = {a[WIDTH-2:0], 1'b0};
                c = a[WIDTH-1];
            end
            OP_SHR: begin
                y = {1'b0, a[WIDTH-1:1]};
                c = a[0];
            end
            default: begin
                y = stage[SHW];
                c = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stack_alu.sv
// Top of the stack ALU. Combinational: steers operands into the shared
// carry chain, bitwise and shifter units and merges result and carry per code.
// Assumes operands are already fetched; unused codes pass A and carry through.
module stack_alu
    import stack_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [4:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    alu_op_e          op;
    logic [WIDTH-1:0] add_x, add_y, add_s;
    logic             add_ci, add_co;
    logic [WIDTH-1:0] bit_y, shf_y;
    logic             shf_c;
    logic             bit_zero;

    assign op = alu_op_e'(op_sel);

    // Operand steering into the shared adder for each arithmetic code.
    always_comb begin
        case (op)
            OP_SUB: begin
                add_x = opnd_b; add_y = ~opnd_a; add_ci = ~carry_in;
            end
            OP_INC: begin
                add_x = opnd_a; add_y = '0;      add_ci = 1'b1;
            end
            OP_DEC: begin
                add_x = opnd_a; add_y = '1;      add_ci = 1'b0;
            end
            OP_NEG: begin
                add_x = '0;     add_y = ~opnd_a; add_ci = 1'b1;
            end
            default: begin
                add_x = opnd_b; add_y = opnd_a;  add_ci = carry_in;
            end
        endcase
    end

    alu_carry_chain #(.WIDTH(WIDTH)) u_chain (
        .x_in (add_x),
        .y_in (add_y),
        .ci   (add_ci),
        .sum  (add_s),
        .co   (add_co)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (bit_y)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (shf_y),
        .c  (shf_c)
    );

    assign bit_zero = (bit_y == '0);

    // Final merge of result byte and flag meaning per operation family.
    always_comb begin
        case (op)
            OP_ADD: begin
                result = add_s; carry_out = add_co;
            end
            OP_SUB: begin
                result = add_s; carry_out = ~add_co;
            end
            OP_INC, OP_DEC, OP_NEG: begin
                result = add_s; carry_out = carry_in;
            end
            OP_SEL: begin
                result = carry_in ? opnd_a : opnd_b; carry_out = carry_in;
            end
            OP_ROT, OP_SHL, OP_SHR: begin
                result = shf_y; carry_out = shf_c;
            end
            OP_OR, OP_AND, OP_XOR, OP_XAND, OP_NOT, OP_BUF: begin
                result = bit_y; carry_out = bit_zero;
            end
            default: begin
                result = opnd_a; carry_out = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/stack_alu_chk.sv
// Checker for stack_alu: immediate assertions over the ports, evaluated
// whenever an input or output changes. Bound to every stack_alu instance.
module stack_alu_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [4:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    logic [WIDTH:0] wide_a, wide_b;
    assign wide_a = {1'b0, opnd_a};
    assign wide_b = {1'b0, opnd_b};

    // Port-level relations per operation code.
    always_comb begin
        if (op_sel == 5'd0)
            p_add_sum_r1: assert ({carry_out, result} == wide_b + wide_a + {{WIDTH{1'b0}}, carry_in})
                else $error("R1 add mismatch");
        if (op_sel == 5'd1)
            p_sub_borrow_r2: assert (carry_out == (wide_b < wide_a + {{WIDTH{1'b0}}, carry_in}))
                else $error("R2 borrow mismatch");
        if (op_sel == 5'd2)
            p_sel_pick_r3: assert (result == (carry_in ? opnd_a : opnd_b) && carry_out == carry_in)
                else $error("R3 select mismatch");
        if (op_sel == 5'd3)
            p_rot_clear_r4: assert (!carry_out && $countones(result) == $countones(opnd_b))
                else $error("R4 rotate mismatch");
        if (op_sel >= 5'd4 && op_sel <= 5'd6)
            p_logic_zero_r5: assert (carry_out == (result == '0))
                else $error("R5 zero flag mismatch");
        if (op_sel == 5'd7)
            p_xand_const_r6: assert (result == '0 && carry_out)
                else $error("R6 xand mismatch");
        if (op_sel == 5'd11)
            p_shl_out_r8: assert (carry_out == opnd_a[WIDTH-1] && !result[0])
                else $error("R8 shl mismatch");
        if (op_sel == 5'd12)
            p_shr_out_r9: assert (carry_out == opnd_a[0] && !result[WIDTH-1])
                else $error("R9 shr mismatch");
        if (op_sel >= 5'd8 && op_sel <= 5'd10)
            p_keep_carry_r10: assert (carry_out == carry_in)
                else $error("R10 carry not kept");
        if (op_sel >= 5'd15)
            p_unused_pass_r11: assert (result == opnd_a && carry_out == carry_in)
                else $error("R11 unused code mismatch");
    end

endmodule

bind stack_alu stack_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_stack_alu.sv
// Self-checking bench for stack_alu: vector table walk, then directed sweeps.
module sim_stack_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       carry_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    stack_alu u0 (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    // Vector layout: op[30:26] a[25:18] b[17:10] cin[9] res[8:1] c[0]
    localparam int NV = 37;
    localparam logic [30:0] VEC [NV] = '{
        {5'd0,  8'h01, 8'h02, 1'b0, 8'h03, 1'b0},  // R1
        {5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1},  // R1 wrap
        {5'd0,  8'h80, 8'h7F, 1'b1, 8'h00, 1'b1},  // R1 carry-in wrap
        {5'd0,  8'h10, 8'h20, 1'b1, 8'h31, 1'b0},  // R1
        {5'd1,  8'h01, 8'h05, 1'b0, 8'h04, 1'b0},  // R2
        {5'd1,  8'h05, 8'h01, 1'b0, 8'hFC, 1'b1},  // R2 borrow
        {5'd1,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1},  // R2 borrow-in only
        {5'd1,  8'h04, 8'h05, 1'b1, 8'h00, 1'b0},  // R2
        {5'd2,  8'hAA, 8'h55, 1'b1, 8'hAA, 1'b1},  // R3
        {5'd2,  8'hAA, 8'h55, 1'b0, 8'h55, 1'b0},  // R3
        {5'd3,  8'h03, 8'h81, 1'b1, 8'h0C, 1'b0},  // R4
        {5'd3,  8'h08, 8'h96, 1'b1, 8'h96, 1'b0},  // R4 amount 8
        {5'd3,  8'h0F, 8'h01, 1'b0, 8'h80, 1'b0},  // R4 low bits only
        {5'd4,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1},  // R5 or zero
        {5'd4,  8'h0F, 8'hF0, 1'b1, 8'hFF, 1'b0},  // R5
        {5'd5,  8'h0F, 8'hF0, 1'b0, 8'h00, 1'b1},  // R5 and zero
        {5'd5,  8'h3C, 8'hF0, 1'b1, 8'h30, 1'b0},  // R5
        {5'd6,  8'h5A, 8'h5A, 1'b0, 8'h00, 1'b1},  // R5 xor zero
        {5'd6,  8'h5A, 8'hA5, 1'b1, 8'hFF, 1'b0},  // R5
        {5'd7,  8'hFF, 8'hFF, 1'b0, 8'h00, 1'b1},  // R6
        {5'd8,  8'hFF, 8'h00, 1'b0, 8'h00, 1'b0},  // R10 inc wrap
        {5'd8,  8'h41, 8'h00, 1'b1, 8'h42, 1'b1},  // R10
        {5'd9,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1},  // R10 dec wrap
        {5'd9,  8'h80, 8'h00, 1'b0, 8'h7F, 1'b0},  // R10
        {5'd10, 8'h01, 8'h00, 1'b0, 8'hFF, 1'b0},  // R10 neg
        {5'd10, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1},  // R10 neg zero
        {5'd10, 8'h80, 8'h00, 1'b0, 8'h80, 1'b0},  // R10 neg min
        {5'd11, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1},  // R8
        {5'd11, 8'h40, 8'h00, 1'b1, 8'h80, 1'b0},  // R8
        {5'd12, 8'h81, 8'h00, 1'b0, 8'h40, 1'b1},  // R9
        {5'd12, 8'h02, 8'h00, 1'b1, 8'h01, 1'b0},  // R9
        {5'd13, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1},  // R7 not zero
        {5'd13, 8'h0F, 8'h00, 1'b1, 8'hF0, 1'b0},  // R7
        {5'd14, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1},  // R7 buf zero
        {5'd14, 8'hC3, 8'h00, 1'b1, 8'hC3, 1'b0},  // R7
        {5'd15, 8'h12, 8'h34, 1'b1, 8'h12, 1'b1},  // R11
        {5'd31, 8'h9A, 8'h00, 1'b0, 8'h9A, 1'b0}   // R11
    };

    // Requirement tag for a given operation code.
    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0: return "R1";
            5'd1: return "R2";
            5'd2: return "R3";
            5'd3: return "R4";
            5'd4, 5'd5, 5'd6: return "R5";
            5'd7: return "R6";
            5'd8, 5'd9, 5'd10: return "R10";
            5'd11: return "R8";
            5'd12: return "R9";
            5'd13, 5'd14: return "R7";
            default: return "R11";
        endcase
    endfunction

    // Drive inputs just after a rising edge, compare at the falling edge.
    task automatic apply_check(input logic [4:0] op, input logic [7:0] a,
                               input logic [7:0] b, input logic ci,
                               input logic [7:0] er, input logic ec,
                               input string req);
        @(posedge clk);
        #1;
        op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
        @(negedge clk);
        n_run++;
        if (result !== er || carry_out !== ec) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%b: got %h/%b expected %h/%b",
                     req, op, a, b, ci, result, carry_out, er, ec);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: idle inputs give add of zeros (R1).
        @(negedge clk);
        n_run++;
        if (result !== 8'h00 || carry_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset idle: got %h/%b expected 00/0", result, carry_out);
        end
        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][30:26], VEC[i][25:18], VEC[i][17:10], VEC[i][9],
                        VEC[i][8:1], VEC[i][0], tag_of(VEC[i][30:26]));
        end
        // R2: equal operands, no borrow-in, never borrow.
        for (int v = 0; v < 256; v++)
            apply_check(5'd1, 8'(v), 8'(v), 1'b0, 8'h00, 1'b0, "R2");
        // R4: single bit rotated by every amount including wrap values.
        for (int n = 0; n < 16; n++)
            apply_check(5'd3, 8'(n), 8'h01, 1'b1, 8'(1 << (n % 8)), 1'b0, "R4");
        // R6: XAND ignores operands.
        for (int v = 0; v < 256; v += 17)
            apply_check(5'd7, 8'(v), 8'(255 - v), 1'(v & 1), 8'h00, 1'b1, "R6");
        // R11: every unused code, both carry values.
        for (int op = 15; op < 32; op++)
            apply_check(5'(op), 8'(op * 7), 8'hE1, 1'(op & 1), 8'(op * 7), 1'(op & 1), "R11");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule